// File: doc/BRIEF.md
# Rotating-Priority Interrupt Vector Generator

This block sits between eight serial channels and a processor bus. It picks one of the pending channel interrupt requests according to a selectable priority scheme. When the processor runs an interrupt acknowledge cycle, the block builds an 8-bit vector and presents it on the data bus for exactly one cycle. The vector combines fixed device address bits with either the granted channel number or a configured address extension.

The winning channel is captured when the acknowledge strobe arrives and is held until the end-of-service pulse. While the grant is held, no new arbitration takes place. There are three priority schemes. The fixed scheme puts channel 0 first. The full rotation scheme makes the channel just serviced the lowest. The pinned rotation scheme keeps channel 0 on top and rotates channels 1 to 7 among themselves.

Top module: `irq_vector_gen`

## Requirements
- R1: In every presented vector, bits 7..5 equal cfg_addr_i[5:3] (the address bits T7, T6, T5) and bits 1..0 are 0.
- R2: With cfg_ext_en_i = 0, vector bits 4..2 carry the binary number of the granted channel.
- R3: With cfg_ext_en_i = 1, vector bits 4..2 carry cfg_addr_i[2:0] (the extension bits T4..T2) and not the channel number.
- R4: vec_oe_o is high only in the cycle after an accepted acknowledge strobe. Whenever vec_oe_o is low, vec_o is 0.
- R5: With cfg_rot_en_i = 0, the lowest-numbered requesting channel wins, and the service history has no effect.
- R6: With cfg_rot_en_i = 1 and cfg_rot_pin_i = 0, the channel whose service ends becomes the lowest priority. The search starts at the next higher channel number and wraps around from 7 to 0.
- R7: With cfg_rot_en_i = 1 and cfg_rot_pin_i = 1, a request on channel 0 always wins. Channels 1..7 rotate among themselves as in R6, and servicing channel 0 leaves their order unchanged.
- R8: The granted index is captured at the acknowledge strobe and stays stable until end of service. A further acknowledge while the grant is held presents the vector of the same channel again, whatever the requests are at that time.
- R9: An acknowledge with no request pending drives no vector and sets no grant.
- R10: end_of_service_i clears the grant in the next cycle. An acknowledge in the same cycle as end_of_service_i is ignored.
- R11: After reset there is no grant, no output enable and a zero vector, and the rotation state ranks channel 0 highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Interrupt request, one bit per channel |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| end_of_service_i | input | 1 | Pulse that ends service of the granted channel |
| cfg_addr_i | input | 6 | Address bits T7..T2, with T7 in bit 5 |
| cfg_ext_en_i | input | 1 | Put the address extension in vector bits 4..2 instead of the channel number |
| cfg_rot_en_i | input | 1 | Enable rotating priority |
| cfg_rot_pin_i | input | 1 | Keep channel 0 fixed on top during rotation |
| vec_o | output | 8 | Interrupt vector byte |
| vec_oe_o | output | 1 | Data bus output enable for the vector |
| grant_valid_o | output | 1 | A grant is held |
| grant_idx_o | output | 3 | Index of the granted channel |

## Verification
The main function is tried with request masks that hold several requests at once. In a single fixed-mode acknowledge, these masks show whether the lowest-index winner is chosen. Repeated all-ones and two-bit masks under full rotation show whether the pointer advances and wraps. Masks that mix channel 0 with higher channels under pinned rotation show that channel 0 stays on top while the others cycle. Address patterns with alternating bits, taken with the extension flag both off and on, tell whether the channel number or the address lands in bits 4..2.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_CH = 8;
    localparam int IDX_W  = $clog2(NUM_CH);
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        PRIO_FIXED   = 2'd0,
        PRIO_ROT_ALL = 2'd1,
        PRIO_ROT_PIN = 2'd2
    } prio_mode_e;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic              oe;
        logic [VEC_W-1:0]  vec;
    } ack_state_t;

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_vec_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    input  prio_mode_e    mode_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    localparam int NROT = N - 1;

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        unique case (mode_i)
            PRIO_ROT_ALL: begin
                // walk from farthest to nearest so nearest wins
                for (int k = N; k >= 1; k--) begin
                    int c;
                    c = (int'(last_i) + k) % N;
                    if (req_i[c]) begin
                        hit_o = 1'b1;
                        idx_o = IW'(c);
                    end
                end
            end
            PRIO_ROT_PIN: begin
                for (int k = NROT; k >= 1; k--) begin
                    int base;
                    int c;
                    base = (last_i == '0) ? NROT : int'(last_i);
                    c    = ((base - 1 + k) % NROT) + 1;
                    if (req_i[c]) begin
                        hit_o = 1'b1;
                        idx_o = IW'(c);
                    end
                end
                if (req_i[0]) begin
                    hit_o = 1'b1;
                    idx_o = '0;
                end
            end
            default: begin
                for (int k = N - 1; k >= 0; k--) begin
                    if (req_i[k]) begin
                        hit_o = 1'b1;
                        idx_o = IW'(k);
                    end
                end
            end
        endcase
    end

    always_comb begin
        if (hit_o) begin
            a_r5_hit_is_request: assert (req_i[idx_o]);
        end
        if (hit_o && mode_i == PRIO_FIXED) begin
            a_r5_no_lower_request: assert (N'(req_i << (N - int'(idx_o))) == '0);
        end
        if (mode_i == PRIO_ROT_PIN && req_i[0]) begin
            a_r7_pin_channel_top: assert (hit_o && idx_o == '0);
        end
        if (req_i == '0) begin
            a_r9_no_hit_when_idle: assert (!hit_o);
        end
    end

endmodule

// File: rtl/irq_rot_ptr.sv
module irq_rot_ptr
    import irq_vec_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [IW-1:0] svc_idx_i,
    input  prio_mode_e    mode_i,
    output logic [IW-1:0] last_o
);

    logic [IW-1:0] last_d, last_q;

    always_comb begin
        last_d = last_q;
        if (upd_i) begin
            if (mode_i == PRIO_ROT_ALL) begin
                last_d = svc_idx_i;
            end else if (mode_i == PRIO_ROT_PIN && svc_idx_i != '0) begin
                last_d = svc_idx_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else begin
            last_q <= last_d;
        end
    end

    assign last_o = last_q;

    a_r7_pin_zero_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && mode_i == PRIO_ROT_PIN && svc_idx_i == '0) |=> $stable(last_o));

    a_r5_fixed_keeps_history: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PRIO_FIXED) |=> $stable(last_o));

endmodule

// File: rtl/irq_vec_compose.sv
module irq_vec_compose
    import irq_vec_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic          ext_en_i,
    input  logic [IW-1:0] idx_i,
    output logic [VW-1:0] vec_o
);

    localparam int SLOT_W = 3;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot  = ext_en_i ? addr_i[SLOT_W-1:0] : SLOT_W'(idx_i);
        vec_o = {addr_i[AW-1:SLOT_W], slot, 2'b00};
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              ack_i,
    input  logic              end_of_service_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic              cfg_ext_en_i,
    input  logic              cfg_rot_en_i,
    input  logic              cfg_rot_pin_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_oe_o,
    output logic              grant_valid_o,
    output logic [IDX_W-1:0]  grant_idx_o
);

    ack_state_t       st_d, st_q;
    prio_mode_e       mode;
    logic             arb_hit;
    logic [IDX_W-1:0] arb_idx;
    logic [IDX_W-1:0] last_svc;
    logic [IDX_W-1:0] sel_idx;
    logic [VEC_W-1:0] vec_next;

    always_comb begin
        if (!cfg_rot_en_i) begin
            mode = PRIO_FIXED;
        end else if (cfg_rot_pin_i) begin
            mode = PRIO_ROT_PIN;
        end else begin
            mode = PRIO_ROT_ALL;
        end
    end

    irq_prio_arb #(.N(NUM_CH), .IW(IDX_W)) arb_i (
        .req_i  (req_i),
        .last_i (last_svc),
        .mode_i (mode),
        .hit_o  (arb_hit),
        .idx_o  (arb_idx)
    );

    irq_rot_ptr #(.N(NUM_CH), .IW(IDX_W)) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (end_of_service_i && st_q.busy),
        .svc_idx_i (st_q.idx),
        .mode_i    (mode),
        .last_o    (last_svc)
    );

    assign sel_idx = st_q.busy ? st_q.idx : arb_idx;

    irq_vec_compose #(.IW(IDX_W), .AW(ADDR_W), .VW(VEC_W)) cmp_i (
        .addr_i   (cfg_addr_i),
        .ext_en_i (cfg_ext_en_i),
        .idx_i    (sel_idx),
        .vec_o    (vec_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.oe  = 1'b0;
        st_d.vec = '0;
        if (end_of_service_i) begin
            st_d.busy = 1'b0;
        end else if (ack_i) begin
            if (st_q.busy) begin
                st_d.oe  = 1'b1;
                st_d.vec = vec_next;
            end else if (arb_hit) begin
                st_d.busy = 1'b1;
                st_d.idx  = arb_idx;
                st_d.oe   = 1'b1;
                st_d.vec  = vec_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o         = st_q.vec;
    assign vec_oe_o      = st_q.oe;
    assign grant_valid_o = st_q.busy;
    assign grant_idx_o   = st_q.idx;

    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (vec_o[7:5] == $past(cfg_addr_i[5:3]) && vec_o[1:0] == 2'b00));

    a_r2_channel_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && !$past(cfg_ext_en_i)) |-> vec_o[4:2] == 3'(grant_idx_o));

    a_r3_ext_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && $past(cfg_ext_en_i)) |-> vec_o[4:2] == $past(cfg_addr_i[2:0]));

    a_r4_oe_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> ($past(ack_i) && !$past(end_of_service_i)));

    a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe_o |-> vec_o == '0);

    a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !end_of_service_i) |=> (grant_valid_o && $stable(grant_idx_o)));

    a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !grant_valid_o && req_i == '0) |=> !vec_oe_o);

    a_r10_eos_clears: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_service_i |=> (!grant_valid_o && !vec_oe_o));

endmodule

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  ROWS       = 12;

    // row: req[19:12] addr[11:6] eda[5] rot[4] pin[3] exp_idx[2:0]
    localparam logic [19:0] TBL [ROWS] = '{
        {8'hA4, 6'b101101, 1'b0, 1'b0, 1'b0, 3'd2},  // R5 fixed, R2
        {8'h80, 6'b010011, 1'b1, 1'b0, 1'b0, 3'd7},  // R5, R3
        {8'hFF, 6'b000000, 1'b0, 1'b1, 1'b0, 3'd0},  // R6 start
        {8'hFF, 6'b000000, 1'b0, 1'b1, 1'b0, 3'd1},  // R6 advance
        {8'h03, 6'b000000, 1'b0, 1'b1, 1'b0, 3'd0},  // R6 wrap
        {8'h03, 6'b000000, 1'b0, 1'b1, 1'b0, 3'd1},  // R6
        {8'h81, 6'b000000, 1'b0, 1'b1, 1'b1, 3'd0},  // R7 ch0 on top
        {8'h86, 6'b000000, 1'b0, 1'b1, 1'b1, 3'd2},  // R7 ptr kept at 1
        {8'h86, 6'b000000, 1'b0, 1'b1, 1'b1, 3'd7},  // R7
        {8'h86, 6'b000000, 1'b0, 1'b1, 1'b1, 3'd1},  // R7 wrap 7->1
        {8'h0C, 6'b111111, 1'b0, 1'b0, 1'b0, 3'd2},  // R5 history ignored, R1
        {8'h40, 6'b110101, 1'b1, 1'b0, 1'b0, 3'd6}   // R3, R1
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       ack, eos;
    logic [5:0] addr;
    logic       eda, rot, pin;
    logic [7:0] vec;
    logic       oe, gvalid;
    logic [2:0] gidx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_gen dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_i            (req),
        .ack_i            (ack),
        .end_of_service_i (eos),
        .cfg_addr_i       (addr),
        .cfg_ext_en_i     (eda),
        .cfg_rot_en_i     (rot),
        .cfg_rot_pin_i    (pin),
        .vec_o            (vec),
        .vec_oe_o         (oe),
        .grant_valid_o    (gvalid),
        .grant_idx_o      (gidx)
    );

    function automatic logic [7:0] exp_vec(logic [5:0] a, logic e, logic [2:0] i);
        return {a[5:3], (e ? a[2:0] : i), 2'b00};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one-cycle acknowledge; returns at the negedge after the capturing edge
    task automatic pulse_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic pulse_eos();
        @(negedge clk) eos = 1'b1;
        @(negedge clk) eos = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        req = '0; ack = 1'b0; eos = 1'b0;
        addr = '0; eda = 1'b0; rot = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 grant_valid", gvalid, 0);
        check("R11 vec_oe", oe, 0);
        check("R11 vec", vec, 0);

        // table walk
        for (int r = 0; r < ROWS; r++) begin
            logic [19:0] row;
            row  = TBL[r];
            req  = row[19:12];
            addr = row[11:6];
            eda  = row[5];
            rot  = row[4];
            pin  = row[3];
            pulse_ack();
            check("R5/R6/R7 grant idx", gidx, row[2:0]);
            check("R8 grant valid", gvalid, 1);
            check("R4 vec_oe after ack", oe, 1);
            check("R1/R2/R3 vector", vec, exp_vec(row[11:6], row[5], row[2:0]));
            @(negedge clk);
            check("R4 oe drops", oe, 0);
            check("R4 vec zero when idle", vec, 0);
            pulse_eos();
            check("R10 grant cleared", gvalid, 0);
        end

        // R11 pointer after reset: full rotation starts at channel 0
        do_reset();
        req = 8'h81; rot = 1'b1; pin = 1'b0; eda = 1'b0; addr = '0;
        pulse_ack();
        check("R11 rotation starts at ch0", gidx, 0);
        pulse_eos();

        // R9 acknowledge with nothing pending
        req = '0; rot = 1'b0;
        pulse_ack();
        check("R9 no vector", oe, 0);
        check("R9 no grant", gvalid, 0);
        check("R9 vec zero", vec, 0);

        // R8 grant held across a second acknowledge
        req = 8'h10; addr = 6'b101000; eda = 1'b0;
        pulse_ack();
        check("R8 first grant", gidx, 4);
        req = 8'h01;
        repeat (3) @(negedge clk);
        check("R8 idx stable", gidx, 4);
        pulse_ack();
        check("R8 re-ack oe", oe, 1);
        check("R8 re-ack idx", gidx, 4);
        check("R8 re-ack vec", vec, exp_vec(6'b101000, 1'b0, 3'd4));

        // R10 end of service together with acknowledge while held
        @(negedge clk) begin ack = 1'b1; eos = 1'b1; end
        @(negedge clk) begin ack = 1'b0; eos = 1'b0; end
        check("R10 ack ignored oe", oe, 0);
        check("R10 grant cleared", gvalid, 0);

        // R10 end of service together with acknowledge while idle
        req = 8'h02;
        @(negedge clk) begin ack = 1'b1; eos = 1'b1; end
        @(negedge clk) begin ack = 1'b0; eos = 1'b0; end
        check("R10 idle ack ignored", gvalid, 0);
        check("R10 idle no vector", oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule